// File: doc/BRIEF.md
# Interruptible Iterative Fixed-Point Divider

This block divides a dividend by a 16-bit divisor. It returns a 16-bit quotient and a 16-bit remainder. It covers a 16-bit or 32-bit dividend, signed or unsigned operands, and integer or Q15 fractional interpretation. The block does not run on its own. An outside repeat controller drives it, one step per cycle in which `step_en` is high, and a complete division always takes nineteen such steps.

The sequence of steps is fixed:

- The first step captures the operands and turns them into magnitudes.
- The next sixteen steps each resolve one quotient bit with a restoring compare-and-subtract.
- The eighteenth step applies the signs.
- The nineteenth step posts the flags and raises `done`.

The controller may drop `step_en` between any two steps, for example while an interrupt is serviced. Every piece of partial state simply holds, so the division continues exactly where it stopped.

Signed division works on magnitudes. The quotient is negated when the operand signs differ, and the remainder carries the sign of the dividend. Two flags report the exceptions:

- A zero divisor raises `div_zero`. The quotient and remainder then take a fixed but meaningless value.
- A quotient that cannot be represented in 16 bits raises `overflow`.

Top module: `iter_divider`

## Requirements
- R1: A division finishes after exactly 19 cycles with `step_en` high. `done` is high for one cycle, immediately after the 19th enabled edge. `busy` is high from the first enabled step until the 19th, and is low while `done` is high.
- R2: A cycle with `step_en` low changes no state. `busy`, `quotient`, `remainder` and both flags hold. A division paused between any steps gives the same result as one run without pauses.
- R3: Operands and mode inputs (`dividend`, `divisor`, `long_mode`, `signed_mode`, `frac_mode`) are sampled only at the first step. Later changes to them have no effect on the result.
- R4: With `long_mode`=0, `signed_mode`=0 and `frac_mode`=0, the block divides `dividend[15:0]` by `divisor` as unsigned numbers. `dividend[31:16]` is ignored.
- R5: With `long_mode`=1 and `frac_mode`=0, the whole 32-bit `dividend` is the numerator.
- R6: With `signed_mode`=1, operands are two's complement, and in 16-bit mode the numerator is `dividend[15:0]`. The quotient magnitude is |N|/|D|, negated when the signs differ. The remainder magnitude is |N| mod |D|, carrying the sign of N.
- R7: With `frac_mode`=1, `dividend[15:0]` and `divisor` are signed Q15 values, regardless of `long_mode` and `signed_mode`. The quotient is the Q15 value trunc(N·2^15/D), with the R6 sign rules; the remainder is that of the scaled division.
- R8: A zero divisor sets `div_zero`=1 and `overflow`=0 at completion.
- R9: `overflow` is set in three cases:
  - unsigned, when the quotient magnitude exceeds 65535;
  - signed or fractional with a non-negative result, when the magnitude exceeds 32767;
  - signed or fractional with a negative result, when the magnitude exceeds 32768.
- R10: After reset, `busy`, `done`, `quotient`, `remainder`, `div_zero` and `overflow` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Advance the division by one step |
| long_mode | input | 1 | 1: 32-bit numerator, 0: 16-bit |
| signed_mode | input | 1 | Two's complement operands |
| frac_mode | input | 1 | Q15 fractional division |
| dividend | input | 32 | Numerator |
| divisor | input | 16 | Denominator |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 16 | Signed or unsigned quotient |
| remainder | output | 16 | Remainder, with the sign of the numerator |
| div_zero | output | 1 | Divisor was zero |
| overflow | output | 1 | Quotient not representable |

## Verification
Unsigned cases include exact boundaries, such as 0xFFFE0001/0xFFFF and a 16-bit dividend with garbage in its upper half. These separate the wide and narrow numerator paths. The four sign combinations of one small division separate quotient sign handling from remainder sign handling. The cases -32768/1 and -32768/-1 probe the asymmetric signed overflow limit, and Q15 cases such as 0.5/-1.0 and -1.0/-1.0 probe fractional scaling and its overflow. Some runs pause for several cycles between steps while the operand inputs are scrambled. Comparing these runs against the unpaused expectations separates true suspension and one-time operand capture from state that leaks while paused.

// File: rtl/div_pkg.sv
package div_pkg;
   typedef enum logic [1:0] {
      PH_LOAD = 2'd0,
      PH_ITER = 2'd1,
      PH_SIGN = 2'd2,
      PH_FLAG = 2'd3
   } div_phase_e;

   typedef struct packed {
      logic wide;
      logic sgn;
      logic frac;
   } div_mode_t;
endpackage

// File: rtl/div_step_seq.sv
module div_step_seq
   import div_pkg::*;
#(
   parameter int W = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       step_en,
   output div_phase_e phase,
   output logic       busy
);
   localparam int STEPS = W + 3;
   localparam int CW    = $clog2(STEPS);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (step_en)
         cnt_q <= (cnt_q == CW'(STEPS - 1)) ? '0 : cnt_q + 1'b1;
   end

   always_comb begin
      if (cnt_q == '0)
         phase = PH_LOAD;
      else if (cnt_q <= CW'(W))
         phase = PH_ITER;
      else if (cnt_q == CW'(W + 1))
         phase = PH_SIGN;
      else
         phase = PH_FLAG;
   end

   assign busy = (cnt_q != '0);

   // R1
   step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(STEPS - 1));

   // R2
   paused_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step_en |=> $stable(cnt_q));
endmodule

// File: rtl/div_operand_prep.sv
module div_operand_prep
   import div_pkg::*;
#(
   parameter int W = 16
) (
   input  div_mode_t          mode,
   input  logic [2*W-1:0]     dividend,
   input  logic [W-1:0]       divisor,
   output logic [2*W-1:0]     num_mag,
   output logic [W-1:0]       den_mag,
   output logic               q_neg,
   output logic               r_neg,
   output logic               sgn_eff,
   output logic               den_zero,
   output logic               pre_ovf
);
   localparam int NW = 2 * W;

   logic           a_neg, d_neg, use_wide;
   logic [W-1:0]   lo_mag;
   logic [NW-1:0]  wide_mag;

   always_comb begin
      sgn_eff  = mode.sgn | mode.frac;
      use_wide = mode.wide & ~mode.frac;
      a_neg    = sgn_eff & (use_wide ? dividend[NW-1] : dividend[W-1]);
      d_neg    = sgn_eff & divisor[W-1];
      lo_mag   = a_neg ? -dividend[W-1:0] : dividend[W-1:0];
      wide_mag = a_neg ? -dividend : dividend;
      den_mag  = d_neg ? -divisor : divisor;
      if (mode.frac)
         num_mag = {1'b0, lo_mag, {(W-1){1'b0}}};
      else if (use_wide)
         num_mag = wide_mag;
      else
         num_mag = {{W{1'b0}}, lo_mag};
      q_neg    = a_neg ^ d_neg;
      r_neg    = a_neg;
      den_zero = (den_mag == '0);
      pre_ovf  = (num_mag[NW-1:W] >= den_mag);
   end
endmodule

// File: rtl/div_restore_step.sv
module div_restore_step #(
   parameter int W = 16
) (
   input  logic [W-1:0] rem_i,
   input  logic         in_bit,
   input  logic [W-1:0] den,
   output logic [W-1:0] rem_o,
   output logic         q_bit
);
   logic [W:0] trial;

   always_comb begin
      trial = {rem_i, in_bit};
      q_bit = (trial >= {1'b0, den});
      rem_o = q_bit ? W'(trial - {1'b0, den}) : trial[W-1:0];
   end
endmodule

// File: rtl/iter_divider.sv
module iter_divider
   import div_pkg::*;
#(
   parameter int W = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           step_en,
   input  logic           long_mode,
   input  logic           signed_mode,
   input  logic           frac_mode,
   input  logic [2*W-1:0] dividend,
   input  logic [W-1:0]   divisor,
   output logic           busy,
   output logic           done,
   output logic [W-1:0]   quotient,
   output logic [W-1:0]   remainder,
   output logic           div_zero,
   output logic           overflow
);
   localparam int            NW   = 2 * W;
   localparam logic [W-1:0]  HALF = W'(1) << (W - 1);

   if (W < 4) begin : g_bad_width
      $error("iter_divider: W must be at least 4");
   end

   div_phase_e     phase;
   div_mode_t      mode;
   logic [NW-1:0]  p_num;
   logic [W-1:0]   p_den;
   logic           p_qneg, p_rneg, p_sgn, p_dz, p_povf;

   logic [W-1:0]   rem_q, low_q, den_q, rem_nx;
   logic           qneg_q, rneg_q, sgn_q, dz_q, povf_q, qbit;

   assign mode = '{wide: long_mode, sgn: signed_mode, frac: frac_mode};

   div_step_seq #(.W(W)) u_seq (
      .clk(clk), .rst_n(rst_n), .step_en(step_en),
      .phase(phase), .busy(busy)
   );

   div_operand_prep #(.W(W)) u_prep (
      .mode(mode), .dividend(dividend), .divisor(divisor),
      .num_mag(p_num), .den_mag(p_den), .q_neg(p_qneg), .r_neg(p_rneg),
      .sgn_eff(p_sgn), .den_zero(p_dz), .pre_ovf(p_povf)
   );

   div_restore_step #(.W(W)) u_step (
      .rem_i(rem_q), .in_bit(low_q[W-1]), .den(den_q),
      .rem_o(rem_nx), .q_bit(qbit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;  low_q <= '0;  den_q <= '0;
         qneg_q <= 1'b0; rneg_q <= 1'b0; sgn_q <= 1'b0;
         dz_q <= 1'b0; povf_q <= 1'b0;
         quotient <= '0; remainder <= '0;
         div_zero <= 1'b0; overflow <= 1'b0; done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (step_en) begin
            unique case (phase)
               PH_LOAD: begin
                  rem_q  <= p_num[NW-1:W];
                  low_q  <= p_num[W-1:0];
                  den_q  <= p_den;
                  qneg_q <= p_qneg;
                  rneg_q <= p_rneg;
                  sgn_q  <= p_sgn;
                  dz_q   <= p_dz;
                  povf_q <= p_povf;
               end
               PH_ITER: begin
                  rem_q <= rem_nx;
                  low_q <= {low_q[W-2:0], qbit};
               end
               PH_SIGN: begin
                  quotient  <= qneg_q ? -low_q : low_q;
                  remainder <= rneg_q ? -rem_q : rem_q;
               end
               PH_FLAG: begin
                  div_zero <= dz_q;
                  overflow <= !dz_q && (povf_q ||
                              (sgn_q && (qneg_q ? (low_q > HALF) : (low_q >= HALF))));
                  done     <= 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   // R1
   done_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(step_en));

   // R1
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R2
   hold_results_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step_en |=> ($stable(quotient) && $stable(remainder) && $stable(div_zero)
                    && $stable(overflow) && !done));

   // R8
   flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(div_zero && overflow));
endmodule

// File: tb/iter_divider_bench.sv
module iter_divider_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step_en = 1'b0;
   logic        long_mode = 1'b0, signed_mode = 1'b0, frac_mode = 1'b0;
   logic [31:0] dividend = '0;
   logic [15:0] divisor = '0;
   logic        busy, done, div_zero, overflow;
   logic [15:0] quotient, remainder;

   int checks = 0;
   int errors = 0;
   int pushed = 0;
   int popped = 0;
   int cyc = 0;

   typedef struct {
      logic [15:0] q;
      logic [15:0] r;
      bit          dz;
      bit          ov;
      string       tag;
   } exp_t;

   exp_t sb[$];

   always #10 clk = ~clk;   // 50 MHz

   iter_divider u_iter_divider (
      .clk(clk), .rst_n(rst_n), .step_en(step_en),
      .long_mode(long_mode), .signed_mode(signed_mode), .frac_mode(frac_mode),
      .dividend(dividend), .divisor(divisor),
      .busy(busy), .done(done), .quotient(quotient), .remainder(remainder),
      .div_zero(div_zero), .overflow(overflow)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
      end
   endtask

   function automatic exp_t model(input bit lg, input bit sg, input bit fr,
                                  input logic [31:0] dvd, input logic [15:0] dvs,
                                  input string tag);
      exp_t   e;
      longint a, b, n, d, qm, rm;
      bit     an, dn, s;
      s = sg | fr;
      if (fr) begin
         a = longint'($signed(dvd[15:0]));
         b = longint'($signed(dvs));
      end else if (s) begin
         a = lg ? longint'($signed(dvd)) : longint'($signed(dvd[15:0]));
         b = longint'($signed(dvs));
      end else begin
         a = lg ? longint'(dvd) : longint'(dvd[15:0]);
         b = longint'(dvs);
      end
      an = (a < 0);
      dn = (b < 0);
      n  = an ? -a : a;
      d  = dn ? -b : b;
      if (fr) n = n << 15;
      e.tag = tag;
      e.dz  = (d == 0);
      e.q   = '0;
      e.r   = '0;
      e.ov  = 1'b0;
      if (!e.dz) begin
         qm = n / d;
         rm = n % d;
         if (!s)             e.ov = (qm > 65535);
         else if (an ^ dn)   e.ov = (qm > 32768);
         else                e.ov = (qm > 32767);
         e.q = 16'((an ^ dn) ? -qm : qm);
         e.r = 16'(an ? -rm : rm);
      end
      return e;
   endfunction

   // Driver: pushes the expected result, then issues 19 steps with optional pauses.
   task automatic run_div(input bit lg, input bit sg, input bit fr,
                          input logic [31:0] dvd, input logic [15:0] dvs,
                          input int gap, input string tag);
      sb.push_back(model(lg, sg, fr, dvd, dvs, tag));
      pushed++;
      long_mode = lg; signed_mode = sg; frac_mode = fr;
      dividend = dvd; divisor = dvs;
      for (int s = 1; s <= 19; s++) begin
         step_en = 1'b1;
         @(negedge clk);
         step_en = 1'b0;
         if (s == 1 && gap > 0) begin
            // R3: scramble every sampled input once the first step is taken
            dividend = ~dvd; divisor = ~dvs + 16'd3;
            long_mode = ~lg; signed_mode = ~sg; frac_mode = ~fr;
         end
         if (s < 19) begin
            chk(busy === 1'b1 && done === 1'b0, "R1", "busy/done mid-run",
                {busy, done}, 2'b10);
            if (gap > 0 && (s % 4 == 1 || s == 18)) begin
               repeat (gap) @(negedge clk);
               chk(busy === 1'b1 && done === 1'b0, "R2", "busy held while paused",
                   {busy, done}, 2'b10);
            end
         end else begin
            chk(done === 1'b1 && busy === 1'b0, "R1", "done after 19th step",
                {busy, done}, 2'b01);
         end
      end
   endtask

   // Monitor: pops expected items and compares on every done pulse.
   always @(negedge clk) begin
      if (rst_n && done === 1'b1) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R1", "unexpected done", 1, 0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            popped++;
            chk(div_zero === e.dz, e.tag, "div_zero", div_zero, e.dz);
            chk(overflow === e.ov, e.tag, "overflow", overflow, e.ov);
            if (!e.dz && !e.ov) begin
               chk(quotient === e.q, e.tag, "quotient", quotient, e.q);
               chk(remainder === e.r, e.tag, "remainder", remainder, e.r);
            end
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, 100000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      chk({busy, done, div_zero, overflow} === 4'b0 && quotient === 16'h0 &&
          remainder === 16'h0, "R10", "reset outputs",
          {busy, done, div_zero, overflow, quotient, remainder}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R2: idle cycles with step_en low start nothing
      repeat (3) @(negedge clk);
      chk(busy === 1'b0 && done === 1'b0, "R2", "idle without step_en",
          {busy, done}, 0);

      run_div(0, 0, 0, 32'h0000_0064, 16'd7, 0, "R4");
      run_div(0, 0, 0, 32'hABCD_0064, 16'd7, 2, "R4");
      run_div(0, 0, 0, 32'h0000_FFFF, 16'd1, 0, "R4");
      run_div(1, 0, 0, 32'h0012_3456, 16'h1234, 3, "R5");
      run_div(1, 0, 0, 32'hFFFE_0001, 16'hFFFF, 0, "R5");
      run_div(1, 0, 0, 32'hFFFF_0000, 16'hFFFF, 0, "R9");
      run_div(0, 1, 0, 32'h0000_FF9C, 16'd7, 0, "R6");
      run_div(0, 1, 0, 32'h0000_0064, 16'hFFF9, 5, "R6");
      run_div(0, 1, 0, 32'h0000_FF9C, 16'hFFF9, 0, "R6");
      run_div(1, 1, 0, 32'hFFF0_BDC0, 16'd1000, 1, "R6");
      run_div(0, 1, 0, 32'h0000_8000, 16'd1, 0, "R9");
      run_div(0, 1, 0, 32'h0000_8000, 16'hFFFF, 0, "R9");
      run_div(1, 1, 0, 32'h0001_0000, 16'd1, 0, "R9");
      run_div(0, 0, 1, 32'h0000_4000, 16'h8000, 0, "R7");
      run_div(1, 0, 1, 32'h0000_2000, 16'h4000, 4, "R7");
      run_div(0, 1, 1, 32'h0000_C000, 16'h7FFF, 0, "R7");
      run_div(0, 0, 1, 32'h0000_8000, 16'h8000, 0, "R9");
      run_div(0, 0, 1, 32'h0000_8000, 16'h7FFF, 0, "R9");
      run_div(0, 0, 0, 32'h0000_1234, 16'h0000, 0, "R8");
      run_div(1, 1, 0, 32'h8000_0000, 16'h0000, 2, "R8");
      run_div(1, 1, 0, 32'h8000_0000, 16'h8000, 6, "R2");

      // R2: results hold while idle after completion
      step_en = 1'b0;
      begin
         logic [15:0] q0, r0;
         q0 = quotient; r0 = remainder;
         repeat (4) @(negedge clk);
         chk(quotient === q0 && remainder === r0, "R2", "results held when idle",
             {quotient, remainder}, {q0, r0});
      end
      chk(sb.size() == 0 && popped == pushed, "R1", "every division completed",
          popped, pushed);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule